// File: doc/BRIEF.md
# Hardwired Fibonacci Sequencer

This block is a small self-timed machine that computes a term of the Fibonacci sequence. It has a controller and a datapath. The datapath holds three working registers: a step counter, the current term and the previous term. It also holds a copy of the requested length. A one-cycle start pulse makes the controller capture the length input and initialise the registers. The controller then advances the sequence by one term per clock. Each advance is a pair of simultaneous register transfers that read only the old values. The machine halts by itself once the counter reaches the captured length.

After it halts, the term stays on the output and the done flag stays high until the next start pulse. All arithmetic wraps at the register width. A length of N returns the N-th term, F(N), counted as F(1) = F(2) = 1. Lengths of 0 and 1 both return 1. A new start pulse is accepted only while the machine is idle or halted.

Top module: `fib_sequencer`

## Requirements
- R1: While rst is high at a clock edge, the machine returns to idle: after that edge, fibValue reads 0 and done reads 0.
- R2: One clock edge after the edge that accepts start, fibValue reads 1. At that point the count register holds 1 and the previous-term register holds 0.
- R3: For a length N (stepLimit as an unsigned number), the halted result on fibValue is F(max(N,1)) modulo 2^16, with F(1) = F(2) = 1.
- R4: If start is accepted at clock edge 0, done first reads 1 after edge max(N,1)+1. It reads 0 after every earlier edge.
- R5: While halted and start is low, done stays 1 and fibValue does not change, even when stepLimit changes.
- R6: A start pulse that arrives while the machine is initialising or running is ignored. The result and the halt time are unchanged.
- R7: stepLimit is captured only on the edge that accepts start. Later changes to it do not affect the run in progress.
- R8: Additions wrap modulo 2^16, so lengths of 25 or more return the wrapped Fibonacci value.
- R9: During the run, the term after each step equals the sum of the two terms before it, one step per clock.
- R10: A start pulse while halted clears done on the next edge and begins a new computation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to begin a computation |
| stepLimit | input | 16 | Requested sequence length N (unsigned) |
| fibValue | output | 16 | Current Fibonacci term |
| done | output | 1 | High while halted holding the result |

## Verification
The bench sweeps every length from 0 to 40. It compares fibValue on every cycle of each run with an arithmetic model of the sequence. This covers the degenerate lengths 0 and 1, the short runs, and the point where 16-bit wrapping begins at length 25. Further long runs at lengths 100, 1000, 5000 and 65535 check the counter's full range and the wrapped results. Each run changes stepLimit right after start, to tell true capture apart from a live input. One run also receives a stray start pulse partway through, to tell an ignored pulse apart from a restart. Back-to-back runs from the halted state, and a reset partway through a run, check the re-entry paths.

// File: rtl/fib_seq_pkg.sv
package fib_seq_pkg;

  // Controller states; every 2-bit code is a legal state.
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_INIT = 2'd1,
    ST_RUN  = 2'd2,
    ST_HALT = 2'd3
  } seqState_e;

  // Strobes from the controller to the datapath.
  typedef struct packed {
    logic captureLimit;
    logic loadInit;
    logic doStep;
  } dpStrobes_t;

endpackage

// File: rtl/fib_seq_ctrl.sv
module fib_seq_ctrl
  import fib_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic       atLimit,
  output dpStrobes_t strobes,
  output logic       done
);

  seqState_e state;
  seqState_e stateNext;
  logic      startOk;

  // A start pulse is accepted only from idle or halt.
  assign startOk = start && (state == ST_IDLE || state == ST_HALT);

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE: if (startOk) stateNext = ST_INIT;
      ST_INIT: stateNext = ST_RUN;
      ST_RUN:  if (atLimit) stateNext = ST_HALT;
      ST_HALT: if (startOk) stateNext = ST_INIT;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= stateNext;
  end

  always_comb begin
    strobes.captureLimit = startOk;
    strobes.loadInit     = (state == ST_INIT);
    strobes.doStep       = (state == ST_RUN) && !atLimit;
  end

  assign done = (state == ST_HALT);

  // R6
  busy_start_chk: assert property (@(posedge clk) disable iff (rst)
    ((state == ST_RUN || state == ST_INIT) && start) |=> (state != ST_INIT));

  // R5
  halt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_HALT && !start) |=> done);

  // R4
  run_exit_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RUN && atLimit) |=> done);

  // R10
  restart_chk: assert property (@(posedge clk) disable iff (rst)
    (done && start) |=> (!done && strobes.loadInit));

endmodule

// File: rtl/fib_seq_datapath.sv
module fib_seq_datapath
  import fib_seq_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  dpStrobes_t       strobes,
  input  logic [WIDTH-1:0] stepLimit,
  output logic             atLimit,
  output logic [WIDTH-1:0] fibValue
);

  localparam logic [WIDTH-1:0] ONE  = WIDTH'(1);
  localparam logic [WIDTH-1:0] ZERO = '0;

  logic [WIDTH-1:0] countReg;
  logic [WIDTH-1:0] fibReg;
  logic [WIDTH-1:0] tempReg;
  logic [WIDTH-1:0] limitReg;

  // Length register: written only when start is accepted.
  always_ff @(posedge clk) begin
    if (rst)                       limitReg <= ZERO;
    else if (strobes.captureLimit) limitReg <= stepLimit;
  end

  // Working registers: both term transfers read the pre-edge values.
  always_ff @(posedge clk) begin
    if (rst) begin
      countReg <= ZERO;
      fibReg   <= ZERO;
      tempReg  <= ZERO;
    end else if (strobes.loadInit) begin
      countReg <= ONE;
      fibReg   <= ONE;
      tempReg  <= ZERO;
    end else if (strobes.doStep) begin
      countReg <= countReg + ONE;
      fibReg   <= fibReg + tempReg;
      tempReg  <= fibReg;
    end
  end

  assign atLimit  = (countReg >= limitReg);
  assign fibValue = fibReg;

  // R2
  init_values_chk: assert property (@(posedge clk) disable iff (rst)
    strobes.loadInit |=> (fibReg == ONE && tempReg == ZERO && countReg == ONE));

  // R5
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!strobes.loadInit && !strobes.doStep) |=>
      ($stable(fibReg) && $stable(tempReg) && $stable(countReg)));

  // R9
  step_pair_chk: assert property (@(posedge clk) disable iff (rst)
    strobes.doStep |=> ((fibReg - tempReg) == $past(tempReg)));

  // R4
  count_bound_chk: assert property (@(posedge clk) disable iff (rst)
    strobes.doStep |-> (countReg < limitReg));

  // R7
  limit_stable_chk: assert property (@(posedge clk) disable iff (rst)
    !strobes.captureLimit |=> $stable(limitReg));

endmodule

// File: rtl/fib_sequencer.sv
module fib_sequencer
  import fib_seq_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [WIDTH-1:0] stepLimit,
  output logic [WIDTH-1:0] fibValue,
  output logic             done
);

  dpStrobes_t strobes;
  logic       atLimit;

  fib_seq_ctrl u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .atLimit (atLimit),
    .strobes (strobes),
    .done    (done)
  );

  fib_seq_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk       (clk),
    .rst       (rst),
    .strobes   (strobes),
    .stepLimit (stepLimit),
    .atLimit   (atLimit),
    .fibValue  (fibValue)
  );

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (fibValue == '0 && !done));

endmodule

// File: tb/fib_sequencer_test.sv
module fib_sequencer_test;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start = 1'b0;
  logic [W-1:0] stepLimit = '0;
  logic [W-1:0] fibValue;
  logic         done;

  int vectors = 0;
  int fails   = 0;

  always #10 clk = ~clk;  // 50 MHz

  fib_sequencer #(.WIDTH(W)) uut (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .stepLimit (stepLimit),
    .fibValue  (fibValue),
    .done      (done)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // One computation of length n. k counts falling edges after start is driven:
  // the value seen at k reflects the register state after rising edge k-1,
  // where edge 0 accepts start. done is expected at k = max(n,1)+2.
  task automatic runCase(input int n, input int pokeAt);
    int steps;
    int expK;
    int k;
    int s;
    logic [W-1:0] mf;
    logic [W-1:0] mt;
    logic [W-1:0] held;
    steps = (n < 1) ? 1 : n;
    expK  = steps + 2;
    k = 0;
    s = 0;
    mf = '0;
    mt = '0;
    @(negedge clk);
    stepLimit = W'(n);
    start = 1'b1;
    @(negedge clk);
    k = 1;
    start = 1'b0;
    stepLimit = ~W'(n);  // R7: a changed length after capture must be ignored
    check(done == 1'b0, "R10 done cleared after start", int'(done), 0);
    while (!done && k < expK + 20) begin
      @(negedge clk);
      k++;
      start = (k == pokeAt);  // R6: stray start while busy
      if (k == 2) begin
        mf = W'(1);
        mt = '0;
        s = 0;
        check(fibValue == W'(1), "R2 first term", int'(fibValue), 1);
      end else begin
        if (s < steps - 1) begin
          {mf, mt} = {mf + mt, mf};
          s++;
        end
        check(fibValue == mf, "R9 per-step term", int'(fibValue), int'(mf));
      end
      if (k < expK)
        check(done == 1'b0, "R4 done early", int'(done), 0);
    end
    start = 1'b0;
    check(k == expK, (pokeAt > 0) ? "R6 halt time" : "R4 halt time", k, expK);
    check(done == 1'b1, "R4 done", int'(done), 1);
    check(fibValue == mf, (n >= 25) ? "R8 wrapped result" : "R3 result",
          int'(fibValue), int'(mf));
    held = fibValue;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      stepLimit = W'(i * 7 + 3);
      check(done == 1'b1 && fibValue == held, "R5 hold", int'(fibValue), int'(held));
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL R4 watchdog: actual hang expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    check(fibValue == '0, "R1 reset value", int'(fibValue), 0);
    check(done == 1'b0, "R1 reset done", int'(done), 0);
    rst = 1'b0;

    // R3 sweep of short lengths, including 0 and 1
    for (int n = 0; n <= 40; n++)
      runCase(n, (n == 20) ? 7 : 0);

    // R1 reset partway through a run
    @(negedge clk);
    stepLimit = W'(30);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (6) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check(fibValue == '0, "R1 mid-run reset value", int'(fibValue), 0);
    check(done == 1'b0, "R1 mid-run reset done", int'(done), 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    check(fibValue == '0 && done == 1'b0, "R1 stays idle", int'(fibValue), 0);

    // R8 long runs, up to the full counter range
    runCase(100, 0);
    runCase(1000, 0);
    runCase(5000, 0);
    runCase(65535, 0);
    runCase(2, 0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule